// File: doc/BRIEF.md
# Synthesizer Divider Programming Interface

This block stores the divider settings of an integer-N frequency synthesizer and presents them to the counters. A 20-bit working word carries a prescaler enable, a 9-bit main count M, a 4-bit swallow count A and a 6-bit reference count R. The word is filled either bit by bit from a serial port or in byte slices from an 8-bit parallel bus. A second 20-bit hop register takes a copy of the working word on command, so a new setting can be staged while the counters keep running from the old one. An 8-bit auxiliary register, loaded from either port, holds feature bits that are passed through to the rest of the chip.

Two mode pins choose among serial, parallel and direct operation. In the first two, a select input for each mode decides whether the counters see the working word or the hop register. In direct mode the counters take their fields straight from dedicated input pins. Every strobe and the serial clock are sampled on a system clock, and action is taken on a detected rising edge, so the block lives entirely in one clock domain.

Top module: `synth_prog_if`

## Requirements
- R1: Synchronous reset clears the working word, the hop register and the auxiliary register to zero.
- R2: In serial mode (`mode_b_i`=0, `mode_s_i`=1), each rising edge of `ser_clk_i` seen while `ser_load_n_i` is low shifts `ser_data_i` into bit 0 of the working word, moving earlier bits up. After 20 bits the first bit sent sits in bit 19. The word layout is prescaler enable in bit 19, M in bits 18:10, A in bits 9:6 and R in bits 5:0.
- R3: A rising edge on `ser_clk_i` while `ser_load_n_i` is high changes no register.
- R4: While `aux_sel_i` is high, serial shifts go into the 8-bit auxiliary register, entering at bit 0, and the working word is left unchanged.
- R5: A rising edge on `ser_load_n_i` or on `hop_i` copies the working word into the hop register, in any mode. If the working word is written in the same cycle, the hop register receives its value from before that write.
- R6: In parallel mode (`mode_b_i`=0, `mode_s_i`=0), a rising edge on `wr_low_i` loads `pbus_i[7]` into the prescaler enable and `pbus_i[6:0]` into M[6:0].
- R7: In parallel mode, a rising edge on `wr_high_i` loads `pbus_i[3:2]` into R[5:4] and `pbus_i[1:0]` into M[8:7].
- R8: In parallel mode, a rising edge on `wr_ar_i` loads `pbus_i[7:4]` into R[3:0] and `pbus_i[3:0]` into A.
- R9: In parallel mode, a rising edge on `aux_sel_i` loads `pbus_i` into the auxiliary register.
- R10: Parallel strobes have no effect outside parallel mode, and serial clock edges have no effect outside serial mode.
- R11: In serial mode, `use_ser_i`=1 drives the outputs from the working word and 0 from the hop register. In parallel mode, `use_par_i` does the same.
- R12: In direct mode (`mode_b_i`=1), the outputs are the prescaler enable from `dir_pre_i`, M[6:0] from `dir_m_i`, A from `dir_a_i` and R[3:0] from `dir_r_i`, with M[8:7] and R[5:4] forced to zero.
- R13: `aux_o` shows the auxiliary register while `aux_en_n_i` is low and is zero while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock, acted on at its rising edge |
| ser_data_i | input | 1 | Serial data bit, most significant first |
| ser_load_n_i | input | 1 | Serial load enable, low allows shifting; rising edge copies to hop |
| aux_sel_i | input | 1 | Serial routing to auxiliary register; parallel auxiliary strobe |
| pbus_i | input | 8 | Parallel data bus |
| wr_low_i | input | 1 | Parallel strobe for prescaler enable and M[6:0] |
| wr_high_i | input | 1 | Parallel strobe for R[5:4] and M[8:7] |
| wr_ar_i | input | 1 | Parallel strobe for R[3:0] and A |
| hop_i | input | 1 | Hop strobe, copies working word to hop register |
| mode_b_i | input | 1 | Direct mode when high |
| mode_s_i | input | 1 | Serial mode when high, parallel when low (with mode_b_i low) |
| use_ser_i | input | 1 | Serial mode source: 1 working word, 0 hop register |
| use_par_i | input | 1 | Parallel mode source: 1 working word, 0 hop register |
| dir_pre_i | input | 1 | Direct prescaler enable |
| dir_m_i | input | 7 | Direct M[6:0] |
| dir_a_i | input | 4 | Direct A |
| dir_r_i | input | 4 | Direct R[3:0] |
| aux_en_n_i | input | 1 | Auxiliary output enable, active low |
| pre_en_o | output | 1 | Prescaler enable to counters |
| m_o | output | 9 | Main count M |
| a_o | output | 4 | Swallow count A |
| r_o | output | 6 | Reference count R |
| aux_o | output | 8 | Auxiliary bits |

## Verification
The hardest case to reach is a write to the working word in the same system-clock cycle as a hop edge, because the two strobes come from separate pins and only line up when driven together. The bench raises a parallel strobe and the hop strobe on the same cycle, then selects the hop register to show that it kept the earlier word. Random sequences also mix mode changes between serial frames and parallel writes, so that strobes arriving in the wrong mode are shown at the outputs to have been ignored.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 6;
    localparam int WORD_W = 1 + M_W + A_W + R_W;
    localparam int AUX_W  = 8;
    localparam int BUS_W  = 8;
    localparam int DM_W   = 7;
    localparam int DR_W   = 4;

    typedef struct packed {
        logic           pre_en;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic [R_W-1:0] r;
    } div_word_t;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } if_mode_t;

    function automatic if_mode_t decode_mode(input logic b, input logic s);
        if (b)      return MODE_DIR;
        else if (s) return MODE_SER;
        else        return MODE_PAR;
    endfunction

    function automatic div_word_t from_direct(input logic pre,
                                              input logic [DM_W-1:0] m,
                                              input logic [A_W-1:0] a,
                                              input logic [DR_W-1:0] r);
        div_word_t w;
        w        = '0;
        w.pre_en = pre;
        w.m      = {{(M_W-DM_W){1'b0}}, m};
        w.a      = a;
        w.r      = {{(R_W-DR_W){1'b0}}, r};
        return w;
    endfunction
endpackage

// File: rtl/sp_rise_det.sv
module sp_rise_det #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Reset holds the history high so a level already high at reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q & {N{~rst}};
endmodule

// File: rtl/sp_word_regs.sv
module sp_word_regs
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  if_mode_t         mode_i,
    input  logic             sdata_i,
    input  logic             shift_ev_i,
    input  logic             aux_route_i,
    input  logic             low_ev_i,
    input  logic             high_ev_i,
    input  logic             ar_ev_i,
    input  logic             aux_ev_i,
    input  logic             hop_ev_i,
    input  logic [BUS_W-1:0] bus_i,
    output div_word_t        prim_o,
    output div_word_t        sec_o,
    output logic [AUX_W-1:0] aux_o
);
    div_word_t        prim_q, sec_q;
    logic [AUX_W-1:0] aux_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            sec_q  <= '0;
            aux_q  <= '0;
        end else begin
            if (hop_ev_i) sec_q <= prim_q;
            if (mode_i == MODE_SER && shift_ev_i) begin
                if (aux_route_i) aux_q  <= {aux_q[AUX_W-2:0], sdata_i};
                else             prim_q <= div_word_t'({prim_q[WORD_W-2:0], sdata_i});
            end
            if (mode_i == MODE_PAR) begin
                if (low_ev_i) begin
                    prim_q.pre_en      <= bus_i[7];
                    prim_q.m[DM_W-1:0] <= bus_i[6:0];
                end
                if (high_ev_i) begin
                    prim_q.r[R_W-1:DR_W] <= bus_i[3:2];
                    prim_q.m[M_W-1:DM_W] <= bus_i[1:0];
                end
                if (ar_ev_i) begin
                    prim_q.r[DR_W-1:0] <= bus_i[7:4];
                    prim_q.a           <= bus_i[3:0];
                end
                if (aux_ev_i) aux_q <= bus_i;
            end
        end
    end

    assign prim_o = prim_q;
    assign sec_o  = sec_q;
    assign aux_o  = aux_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (prim_q == '0 && sec_q == '0 && aux_q == '0));

    // R5
    hop_copy_chk: assert property (@(posedge clk) disable iff (rst)
        hop_ev_i |=> sec_q == $past(prim_q));

    // R4
    aux_route_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SER && aux_route_i) |=> $stable(prim_q));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_DIR) |=> ($stable(prim_q) && $stable(aux_q)));
endmodule

// File: rtl/sp_out_sel.sv
module sp_out_sel
    import synth_prog_pkg::*;
(
    input  if_mode_t        mode_i,
    input  logic            use_ser_i,
    input  logic            use_par_i,
    input  div_word_t       prim_i,
    input  div_word_t       sec_i,
    input  logic            dir_pre_i,
    input  logic [DM_W-1:0] dir_m_i,
    input  logic [A_W-1:0]  dir_a_i,
    input  logic [DR_W-1:0] dir_r_i,
    output div_word_t       word_o
);
    always_comb begin
        unique case (mode_i)
            MODE_SER: word_o = use_ser_i ? prim_i : sec_i;
            MODE_PAR: word_o = use_par_i ? prim_i : sec_i;
            default:  word_o = from_direct(dir_pre_i, dir_m_i, dir_a_i, dir_r_i);
        endcase
    end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synth_prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk_i,
    input  logic                 ser_data_i,
    input  logic                 ser_load_n_i,
    input  logic                 aux_sel_i,
    input  logic [BUS_W-1:0]     pbus_i,
    input  logic                 wr_low_i,
    input  logic                 wr_high_i,
    input  logic                 wr_ar_i,
    input  logic                 hop_i,
    input  logic                 mode_b_i,
    input  logic                 mode_s_i,
    input  logic                 use_ser_i,
    input  logic                 use_par_i,
    input  logic                 dir_pre_i,
    input  logic [DM_W-1:0]      dir_m_i,
    input  logic [A_W-1:0]       dir_a_i,
    input  logic [DR_W-1:0]      dir_r_i,
    input  logic                 aux_en_n_i,
    output logic                 pre_en_o,
    output logic [M_W-1:0]       m_o,
    output logic [A_W-1:0]       a_o,
    output logic [R_W-1:0]       r_o,
    output logic [AUX_W-1:0]     aux_o
);
    localparam int NSTB = 6;

    logic [NSTB-1:0] stb_lvl, stb_rise;
    if_mode_t        mode;
    div_word_t       prim, sec, word;
    logic [AUX_W-1:0] aux_q;
    logic            shift_ev, hop_ev;

    assign stb_lvl = {ser_clk_i, ser_load_n_i, hop_i, wr_low_i, wr_high_i, wr_ar_i};

    sp_rise_det #(.N(NSTB)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (stb_lvl),
        .rise_o (stb_rise)
    );

    logic aux_rise;
    sp_rise_det #(.N(1)) u_aux_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (aux_sel_i),
        .rise_o (aux_rise)
    );

    assign mode     = decode_mode(mode_b_i, mode_s_i);
    assign shift_ev = stb_rise[5] & ~ser_load_n_i;
    assign hop_ev   = stb_rise[4] | stb_rise[3];

    sp_word_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .sdata_i     (ser_data_i),
        .shift_ev_i  (shift_ev),
        .aux_route_i (aux_sel_i),
        .low_ev_i    (stb_rise[2]),
        .high_ev_i   (stb_rise[1]),
        .ar_ev_i     (stb_rise[0]),
        .aux_ev_i    (aux_rise),
        .hop_ev_i    (hop_ev),
        .bus_i       (pbus_i),
        .prim_o      (prim),
        .sec_o       (sec),
        .aux_o       (aux_q)
    );

    sp_out_sel u_sel (
        .mode_i    (mode),
        .use_ser_i (use_ser_i),
        .use_par_i (use_par_i),
        .prim_i    (prim),
        .sec_i     (sec),
        .dir_pre_i (dir_pre_i),
        .dir_m_i   (dir_m_i),
        .dir_a_i   (dir_a_i),
        .dir_r_i   (dir_r_i),
        .word_o    (word)
    );

    assign pre_en_o = word.pre_en;
    assign m_o      = word.m;
    assign a_o      = word.a;
    assign r_o      = word.r;
    assign aux_o    = aux_en_n_i ? '0 : aux_q;

    // R13
    aux_gate_chk: assert property (@(posedge clk) disable iff (rst)
        aux_en_n_i |-> aux_o == '0);

    // R12
    dir_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mode_b_i |-> (m_o[M_W-1:DM_W] == '0 && r_o[R_W-1:DR_W] == '0));

    // R3
    ser_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_load_n_i && !hop_i && !mode_b_i && mode_s_i && $past(ser_load_n_i))
            |=> $stable(prim));
endmodule

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
    import synth_prog_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk_i = 0, ser_data_i = 0, ser_load_n_i = 1, aux_sel_i = 0;
    logic [7:0] pbus_i = 0;
    logic wr_low_i = 0, wr_high_i = 0, wr_ar_i = 0, hop_i = 0;
    logic mode_b_i = 0, mode_s_i = 1, use_ser_i = 1, use_par_i = 1;
    logic dir_pre_i = 0;
    logic [6:0] dir_m_i = 0;
    logic [3:0] dir_a_i = 0, dir_r_i = 0;
    logic aux_en_n_i = 0;
    logic pre_en_o;
    logic [8:0] m_o;
    logic [3:0] a_o;
    logic [5:0] r_o;
    logic [7:0] aux_o;

    int checks = 0, errors = 0;
    bit done = 0;
    div_word_t mprim, msec;
    logic [7:0] maux;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_if i_synth_prog_if (.*);

    function automatic div_word_t exp_word();
        div_word_t w;
        if (mode_b_i) begin
            w = '0;
            w.pre_en = dir_pre_i; w.m[6:0] = dir_m_i; w.a = dir_a_i; w.r[3:0] = dir_r_i;
        end else if (mode_s_i) w = use_ser_i ? mprim : msec;
        else                   w = use_par_i ? mprim : msec;
        return w;
    endfunction

    function automatic logic [7:0] exp_aux();
        return aux_en_n_i ? 8'h00 : maux;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req);
        logic [19:0] got_w, exp_w;
        got_w = {pre_en_o, m_o, a_o, r_o};
        exp_w = exp_word();
        checks++;
        if (got_w !== exp_w || aux_o !== exp_aux()) begin
            errors++;
            $display("FAIL %s: word=%h aux=%h expected word=%h aux=%h",
                     req, got_w, aux_o, exp_w, exp_aux());
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_data_i = b; ser_clk_i = 1; tick();
        if (!mode_b_i && mode_s_i && !ser_load_n_i) begin
            if (aux_sel_i) maux  = {maux[6:0], b};
            else           mprim = div_word_t'({mprim[18:0], b});
        end
        ser_clk_i = 0; tick();
    endtask

    task automatic ser_frame(input int n, input logic [19:0] d, input logic route);
        aux_sel_i = route; ser_load_n_i = 0; tick();
        for (int i = n - 1; i >= 0; i--) shift_bit(d[i]);
        ser_load_n_i = 1; tick();
        msec = mprim;
        aux_sel_i = 0; tick();
    endtask

    function automatic void par_model(input int which, input logic [7:0] d);
        if (mode_b_i || mode_s_i) return;
        case (which)
            0: begin mprim.pre_en = d[7]; mprim.m[6:0] = d[6:0]; end
            1: begin mprim.r[5:4] = d[3:2]; mprim.m[8:7] = d[1:0]; end
            2: begin mprim.r[3:0] = d[7:4]; mprim.a = d[3:0]; end
            default: maux = d;
        endcase
    endfunction

    task automatic par_write(input int which, input logic [7:0] d, input logic with_hop);
        pbus_i = d;
        case (which)
            0: wr_low_i = 1;
            1: wr_high_i = 1;
            2: wr_ar_i = 1;
            default: aux_sel_i = 1;
        endcase
        hop_i = with_hop;
        tick();
        if (with_hop) msec = mprim;
        par_model(which, d);
        wr_low_i = 0; wr_high_i = 0; wr_ar_i = 0; aux_sel_i = 0; hop_i = 0;
        tick();
    endtask

    task automatic hop_pulse();
        hop_i = 1; tick(); msec = mprim; hop_i = 0; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mprim = '0; msec = '0; maux = '0;
        tick(); tick(); rst = 0; tick();
        chk("R1 reset working word");
        use_ser_i = 0; tick(); chk("R1 reset hop register");

        // R2 serial frame, check field layout then copy to hop
        use_ser_i = 1;
        ser_frame(20, 20'hA5C3E, 0); chk("R2 serial frame");
        use_ser_i = 0; tick(); chk("R5 hop copy on load rise");

        // R3 clock edges with load enable high
        use_ser_i = 1;
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        chk("R3 shift ignored while load high");

        // R4 auxiliary routing
        ser_frame(8, 20'h0005A, 1); chk("R4 serial aux route");
        aux_en_n_i = 1; tick(); chk("R13 aux gated off");
        aux_en_n_i = 0; tick();

        // R6 R7 R8 R9 parallel writes
        mode_s_i = 0; use_par_i = 1; tick();
        par_write(0, 8'hD3, 0); chk("R6 low slice write");
        par_write(1, 8'h0E, 0); chk("R7 high slice write");
        par_write(2, 8'h96, 0); chk("R8 A/R slice write");
        par_write(3, 8'h3C, 0); chk("R9 parallel aux write");

        // R5 same-cycle write and hop
        hop_pulse();
        par_write(2, 8'h71, 1);
        use_par_i = 0; tick(); chk("R5 hop keeps pre-write word");
        use_par_i = 1; tick(); chk("R11 parallel select working word");

        // R10 parallel strobe in serial mode, serial shift in parallel mode
        mode_s_i = 1; tick();
        par_write(0, 8'hFF, 0); chk("R10 parallel strobe ignored in serial mode");
        mode_s_i = 0; ser_load_n_i = 0; tick();
        shift_bit(1); shift_bit(0);
        ser_load_n_i = 1; tick(); msec = mprim;
        chk("R10 serial ignored in parallel mode");

        // R12 direct mode
        mode_b_i = 1; dir_pre_i = 1; dir_m_i = 7'h7F; dir_a_i = 4'hF; dir_r_i = 4'hF;
        tick(); chk("R12 direct mode all ones");
        par_write(1, 8'hFF, 0); chk("R12 direct mode ignores writes");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int act;
            act = $urandom_range(0, 6);
            case (act)
                0: begin mode_b_i = 0; mode_s_i = 1; tick();
                         ser_frame(20, 20'($urandom), 0); end
                1: begin mode_b_i = 0; mode_s_i = 1; tick();
                         ser_frame(8, 20'($urandom), 1); end
                2: par_write($urandom_range(0, 3), 8'($urandom), 1'($urandom));
                3: hop_pulse();
                4: begin mode_b_i = ($urandom_range(0, 3) == 0); mode_s_i = 1'($urandom);
                         tick(); end
                5: begin use_ser_i = 1'($urandom); use_par_i = 1'($urandom);
                         aux_en_n_i = ($urandom_range(0, 3) == 0); tick(); end
                default: begin dir_pre_i = 1'($urandom); dir_m_i = 7'($urandom);
                         dir_a_i = 4'($urandom); dir_r_i = 4'($urandom); tick(); end
            endcase
            chk("R11 random sequence");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule